// File: doc/BRIEF.md
# Audio DMA Descriptor Queue

This block is the descriptor front end for one direction of an audio DMA channel. Software hands the channel buffers to work on by writing a byte length and then a start address. The address write places the pair into a submission queue. A transfer engine, modelled here only by a valid/done handshake, takes descriptors from the head of that queue in order. When the engine signals that a buffer is finished, the descriptor moves unchanged into a completion queue.

Software drains the completion queue by reading the address word and then the length word of the head entry. It adds them to find where the next buffer starts. It refills the submission queue by subtracting the submission level from the queue depth.

Both queue levels are packed into one interrupt status word. An interrupt line reports completed descriptors. It is gated by an enable bit and a level threshold. Pending bits are cleared by writing zero to them.

Top module: `audio_desc_queue`

## Requirements
- R1: After synchronous reset both queue levels are 0, the status word reads 0, `irq` is low and `eng_valid` is low.
- R2: A write to offset 0x18 stages a length. A write to offset 0x14 pushes {address = written data, length = staged value} onto the submission queue. Status word (offset 0x04) bits 11:8 report the submission level.
- R3: An address write while the submission queue holds DEPTH entries is dropped and sets sticky status bit 2. The level never exceeds DEPTH.
- R4: `eng_valid` is high exactly when configuration bit 31 (offset 0x00) is set, the submission queue is not empty and the completion queue is not full. `eng_addr` and `eng_len` then show the oldest submitted descriptor, and 0 otherwise. `eng_done` with `eng_valid` high moves that descriptor unchanged to the completion queue. `eng_done` with `eng_valid` low has no effect.
- R5: With configuration bit 31 clear, no descriptor is consumed.
- R6: Reading offset 0x1C returns the head completion address, and reading 0x20 returns its length. The entry is removed only by a 0x20 read that follows a 0x1C read of the same entry. A 0x20 read without the preceding address read leaves the entry in place. Status bits 15:12 report the completion level.
- R7: Reading 0x1C or 0x20 while the completion queue is empty returns 0 and changes no level.
- R8: Status bit 1 sets on every accepted completion. A write to 0x04 clears each of bits 3:0 that is written 0. If a completion lands in the same cycle as a clearing write, the bit stays set.
- R9: `irq` = enable bit 1 (offset 0x08) AND status bit 1 AND (completion level >= threshold in offset 0x10 bits 3:0).
- R10: A completion push and a software pop in the same cycle leave the completion level unchanged. A submission push and an engine take in the same cycle leave the submission level unchanged.
- R11: Offsets 0x0C and 0x24 are plain read/write storage (0x0C keeps bits 3:0). Offset 0x14, misaligned addresses and unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (pops act on it) |
| bus_addr | input | BUS_AW | Byte address, 4-byte stride |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from address |
| irq | output | 1 | Completion interrupt |
| eng_valid | output | 1 | Head descriptor offered to the engine |
| eng_addr | output | 32 | Offered buffer address |
| eng_len | output | 32 | Offered buffer length |
| eng_done | input | 1 | Engine finished the offered buffer |

## Verification
An engine completion and a software pop of the completion queue can fall in the same cycle. The same holds for a submission write and an engine take of the submission queue, and for a pending-bit set and a clearing write to the status word. The bench provokes these coincidences on purpose: it asserts `eng_done` during the length read that ends a retrieval, and it issues status clears on completion cycles. Random traffic adds more such cycles. After each coincidence the bench judges the outcome against a queue model, through the packed levels, the order of the retrieved descriptors and the interrupt line.

// File: rtl/adq_pkg.sv
// Shared types and register word indices for the audio descriptor queue.
// Assumes a 32-bit address and a 32-bit byte length per descriptor.
package adq_pkg;
    localparam int ADQ_DW = 32;

    typedef struct packed {
        logic [ADQ_DW-1:0] addr;
        logic [ADQ_DW-1:0] len;
    } adq_desc_t;

    // Word indices (byte offset / 4); software decodes these positions.
    localparam logic [4:0] IX_CFG   = 5'd0;
    localparam logic [4:0] IX_STAT  = 5'd1;
    localparam logic [4:0] IX_IEN   = 5'd2;
    localparam logic [4:0] IX_ITHR  = 5'd3;
    localparam logic [4:0] IX_OTHR  = 5'd4;
    localparam logic [4:0] IX_IADDR = 5'd5;
    localparam logic [4:0] IX_ILEN  = 5'd6;
    localparam logic [4:0] IX_OADDR = 5'd7;
    localparam logic [4:0] IX_OLEN  = 5'd8;
    localparam logic [4:0] IX_CFG2  = 5'd9;

    // Status word field positions.
    localparam int ST_PEND = 1;
    localparam int ST_OVF  = 2;
    localparam int ST_ILVL = 8;
    localparam int ST_OLVL = 12;
    localparam int CFG_EN  = 31;
endpackage

// File: rtl/adq_fifo.sv
// Synchronous descriptor FIFO with an occupancy count.
// Assumes the caller pushes only when not full and pops only when not empty.
// The head entry is visible combinationally on dout.
module adq_fifo
    import adq_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic             pop,
    input  adq_desc_t        din,
    output adq_desc_t        dout,
    output logic [CNT_W-1:0] count,
    output logic             full,
    output logic             empty
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);

    adq_desc_t        mem [DEPTH];
    logic [IDX_W-1:0] wr_ptr, rd_ptr;

    function automatic logic [IDX_W-1:0] nxt(input logic [IDX_W-1:0] p);
        return (p == LAST) ? '0 : p + 1'b1;
    endfunction

    // Storage write, no reset needed on data.
    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= din;
    end

    // Pointer and occupancy tracking.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= nxt(wr_ptr);
            if (pop)  rd_ptr <= nxt(rd_ptr);
            count <= count + CNT_W'(push) - CNT_W'(pop);
        end
    end

    assign dout  = mem[rd_ptr];
    assign full  = (count == CNT_W'(DEPTH));
    assign empty = (count == '0);
endmodule

// File: rtl/adq_csr.sv
// Register file of the descriptor queue: decode, submission staging,
// retrieval sequencing, sticky status and interrupt generation.
// Assumes levels fit the 4-bit status fields (DEPTH <= 15).
module adq_csr
    import adq_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int BUS_AW = 7,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [BUS_AW-1:0] bus_addr,
    input  logic [ADQ_DW-1:0] bus_wdata,
    output logic [ADQ_DW-1:0] bus_rdata,
    input  logic [CNT_W-1:0]  in_cnt,
    input  logic [CNT_W-1:0]  out_cnt,
    input  logic              in_full,
    input  logic              out_empty,
    input  adq_desc_t         out_head,
    input  logic              done_acc,
    output logic              sub_push,
    output adq_desc_t         sub_desc,
    output logic              out_pop,
    output logic              ovf_set,
    output logic              chan_en,
    output logic              irq_en,
    output logic              sts_pend,
    output logic              sts_ovf,
    output logic              irq
);
    logic [ADQ_DW-1:0] cfg_q, cfg2_q, stage_len;
    logic [3:0]        ithr_q, othr_q;
    logic              addr_seen;
    logic              hit;
    logic [4:0]        idx;
    logic              wr_stat, oaddr_rd;

    // Aligned, in-map access decode.
    assign hit = (bus_addr[1:0] == 2'b00);
    assign idx = 5'(bus_addr[BUS_AW-1:2]);

    function automatic logic wsel(input logic [4:0] i);
        return bus_wr && hit && (idx == i);
    endfunction

    function automatic logic rsel(input logic [4:0] i);
        return bus_rd && hit && (idx == i);
    endfunction

    assign sub_push = wsel(IX_IADDR) && !in_full;
    assign ovf_set  = wsel(IX_IADDR) && in_full;
    assign sub_desc = '{addr: bus_wdata, len: stage_len};
    assign oaddr_rd = rsel(IX_OADDR) && !out_empty;
    assign out_pop  = rsel(IX_OLEN) && !out_empty && addr_seen;
    assign wr_stat  = wsel(IX_STAT);
    assign chan_en  = cfg_q[CFG_EN];

    // Plain configuration storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q     <= '0;
            cfg2_q    <= '0;
            stage_len <= '0;
            ithr_q    <= '0;
            othr_q    <= '0;
            irq_en    <= 1'b0;
        end else begin
            if (wsel(IX_CFG))  cfg_q     <= bus_wdata;
            if (wsel(IX_CFG2)) cfg2_q    <= bus_wdata;
            if (wsel(IX_ILEN)) stage_len <= bus_wdata;
            if (wsel(IX_ITHR)) ithr_q    <= bus_wdata[3:0];
            if (wsel(IX_OTHR)) othr_q    <= bus_wdata[3:0];
            if (wsel(IX_IEN))  irq_en    <= bus_wdata[ST_PEND];
        end
    end

    // Retrieval sequencing: address read arms the pop on the length read.
    always_ff @(posedge clk) begin
        if (!rst_n)        addr_seen <= 1'b0;
        else if (out_pop)  addr_seen <= 1'b0;
        else if (oaddr_rd) addr_seen <= 1'b1;
    end

    // Sticky status bits: write-zero clears, a new event in the same cycle wins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sts_pend <= 1'b0;
            sts_ovf  <= 1'b0;
        end else begin
            sts_pend <= done_acc || (sts_pend && !(wr_stat && !bus_wdata[ST_PEND]));
            sts_ovf  <= ovf_set  || (sts_ovf  && !(wr_stat && !bus_wdata[ST_OVF]));
        end
    end

    // Interrupt: enabled, pending and completion level at threshold.
    assign irq = irq_en && sts_pend && (4'(out_cnt) >= othr_q);

    // Read data multiplexer.
    always_comb begin
        bus_rdata = '0;
        if (hit) begin
            case (idx)
                IX_CFG:   bus_rdata = cfg_q;
                IX_STAT: begin
                    bus_rdata[ST_OLVL +: 4] = 4'(out_cnt);
                    bus_rdata[ST_ILVL +: 4] = 4'(in_cnt);
                    bus_rdata[ST_OVF]       = sts_ovf;
                    bus_rdata[ST_PEND]      = sts_pend;
                end
                IX_IEN:   bus_rdata[ST_PEND] = irq_en;
                IX_ITHR:  bus_rdata[3:0] = ithr_q;
                IX_OTHR:  bus_rdata[3:0] = othr_q;
                IX_ILEN:  bus_rdata = stage_len;
                IX_OADDR: bus_rdata = out_empty ? '0 : out_head.addr;
                IX_OLEN:  bus_rdata = out_empty ? '0 : out_head.len;
                IX_CFG2:  bus_rdata = cfg2_q;
                default:  bus_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/audio_desc_queue.sv
// Descriptor queue front end for one audio DMA direction: a submission
// FIFO feeding an engine handshake and a completion FIFO drained by software.
// Assumes the engine holds eng_done for one cycle per finished buffer.
module audio_desc_queue
    import adq_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int BUS_AW = 7,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [BUS_AW-1:0] bus_addr,
    input  logic [ADQ_DW-1:0] bus_wdata,
    output logic [ADQ_DW-1:0] bus_rdata,
    output logic              irq,
    output logic              eng_valid,
    output logic [ADQ_DW-1:0] eng_addr,
    output logic [ADQ_DW-1:0] eng_len,
    input  logic              eng_done
);
    adq_desc_t        in_head, out_head, sub_desc;
    logic [CNT_W-1:0] in_cnt, out_cnt;
    logic             in_full, in_empty, out_full, out_empty;
    logic             sub_push, out_pop, done_acc, ovf_set;
    logic             chan_en, irq_en, sts_pend, sts_ovf;

    // Engine handshake: offer the head when running and there is room to complete.
    assign eng_valid = chan_en && !in_empty && !out_full;
    assign done_acc  = eng_done && eng_valid;
    assign eng_addr  = eng_valid ? in_head.addr : '0;
    assign eng_len   = eng_valid ? in_head.len  : '0;

    adq_fifo #(.DEPTH(DEPTH)) u_sub_q (
        .clk(clk), .rst_n(rst_n),
        .push(sub_push), .pop(done_acc), .din(sub_desc),
        .dout(in_head), .count(in_cnt), .full(in_full), .empty(in_empty)
    );

    adq_fifo #(.DEPTH(DEPTH)) u_cpl_q (
        .clk(clk), .rst_n(rst_n),
        .push(done_acc), .pop(out_pop), .din(in_head),
        .dout(out_head), .count(out_cnt), .full(out_full), .empty(out_empty)
    );

    adq_csr #(.DEPTH(DEPTH), .BUS_AW(BUS_AW)) u_csr (
        .clk(clk), .rst_n(rst_n),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .in_cnt(in_cnt), .out_cnt(out_cnt),
        .in_full(in_full), .out_empty(out_empty), .out_head(out_head),
        .done_acc(done_acc),
        .sub_push(sub_push), .sub_desc(sub_desc), .out_pop(out_pop),
        .ovf_set(ovf_set), .chan_en(chan_en), .irq_en(irq_en),
        .sts_pend(sts_pend), .sts_ovf(sts_ovf), .irq(irq)
    );
endmodule

// File: rtl/adq_chk.sv
// Property checker for the descriptor queue, attached by bind.
// Observes queue levels, the handshake and sticky status over time.
module adq_chk #(
    parameter int DEPTH = 8,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic [CNT_W-1:0] in_cnt,
    input logic [CNT_W-1:0] out_cnt,
    input logic             eng_valid,
    input logic             eng_done,
    input logic             chan_en,
    input logic             out_pop,
    input logic             ovf_set,
    input logic             irq_en,
    input logic             sts_pend,
    input logic             sts_ovf,
    input logic             irq
);
    // R1
    rst_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (in_cnt == '0 && out_cnt == '0 && !irq));

    // R3
    level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_cnt <= CNT_W'(DEPTH)) && (out_cnt <= CNT_W'(DEPTH)));

    // R3
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_set |=> sts_ovf);

    // R5
    halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !chan_en |-> !eng_valid);

    // R10
    move_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_done && eng_valid && !out_pop) |=> out_cnt == CNT_W'($past(out_cnt) + 1'b1));

    // R8
    pend_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_done && eng_valid) |=> sts_pend);

    // R9
    irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (irq_en && sts_pend));
endmodule

bind audio_desc_queue adq_chk #(.DEPTH(DEPTH)) u_adq_chk (
    .clk(clk), .rst_n(rst_n), .in_cnt(in_cnt), .out_cnt(out_cnt),
    .eng_valid(eng_valid), .eng_done(eng_done), .chan_en(chan_en),
    .out_pop(out_pop), .ovf_set(ovf_set), .irq_en(irq_en),
    .sts_pend(sts_pend), .sts_ovf(sts_ovf), .irq(irq)
);

// File: tb/tb_audio_desc_queue.sv
// Bench: directed corner cases plus seeded random traffic, every cycle
// compared against a queue model kept in the bench.
module tb_audio_desc_queue;
    localparam int CLK_PERIOD = 10;
    localparam int D = 8;
    localparam logic [6:0] A_CFG = 7'h00, A_STAT = 7'h04, A_IEN = 7'h08,
        A_ITHR = 7'h0C, A_OTHR = 7'h10, A_IADDR = 7'h14, A_ILEN = 7'h18,
        A_OADDR = 7'h1C, A_OLEN = 7'h20, A_CFG2 = 7'h24;

    logic clk = 1'b0, rst_n = 1'b0;
    logic bus_wr = 0, bus_rd = 0, eng_done = 0;
    logic [6:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata, eng_addr, eng_len;
    logic irq, eng_valid;

    int n_cmp = 0, n_bad = 0;

    // Model state.
    logic [63:0] mq_in[$], mq_out[$];
    logic [31:0] m_cfg = 0, m_cfg2 = 0, m_stage = 0;
    logic [3:0]  m_ithr = 0, m_othr = 0;
    logic m_ien = 0, m_pend = 0, m_ovf = 0, m_seen = 0;

    audio_desc_queue dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq), .eng_valid(eng_valid), .eng_addr(eng_addr),
        .eng_len(eng_len), .eng_done(eng_done)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] exp_read(input logic [6:0] a);
        logic [31:0] v = '0;
        if (a[1:0] != 2'b00) return '0;
        case (a)
            A_CFG:   v = m_cfg;
            A_STAT:  begin
                v[15:12] = 4'(mq_out.size());
                v[11:8]  = 4'(mq_in.size());
                v[2] = m_ovf; v[1] = m_pend;
            end
            A_IEN:   v[1] = m_ien;
            A_ITHR:  v[3:0] = m_ithr;
            A_OTHR:  v[3:0] = m_othr;
            A_ILEN:  v = m_stage;
            A_OADDR: v = (mq_out.size() > 0) ? mq_out[0][63:32] : '0;
            A_OLEN:  v = (mq_out.size() > 0) ? mq_out[0][31:0] : '0;
            A_CFG2:  v = m_cfg2;
            default: v = '0;
        endcase
        return v;
    endfunction

    // One bus/engine cycle: drive, compare before the edge, advance model.
    task automatic step(input logic wr, input logic rd, input logic [6:0] a,
                        input logic [31:0] wd, input logic done, input string tag);
        int ni, no;
        logic vexp, dacc, popo, ordd;
        @(negedge clk);
        bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = wd; eng_done = done;
        #1;
        ni = mq_in.size(); no = mq_out.size();
        vexp = m_cfg[31] && ni > 0 && no < D;
        check("R4 valid", 32'(eng_valid), 32'(vexp));
        check("R4 addr", eng_addr, vexp ? mq_in[0][63:32] : '0);
        check("R4 len", eng_len, vexp ? mq_in[0][31:0] : '0);
        check("R9 irq", 32'(irq), 32'(m_ien && m_pend && (4'(no) >= m_othr)));
        if (rd) check(tag, bus_rdata, exp_read(a));
        dacc = done && vexp;
        popo = rd && a == A_OLEN && no > 0 && m_seen;
        ordd = rd && a == A_OADDR && no > 0;
        if (popo) void'(mq_out.pop_front());
        if (dacc) mq_out.push_back(mq_in.pop_front());
        m_pend = dacc || (m_pend && !(wr && a == A_STAT && !wd[1]));
        m_ovf  = (wr && a == A_IADDR && ni == D) || (m_ovf && !(wr && a == A_STAT && !wd[2]));
        if (wr && a == A_IADDR && ni < D) mq_in.push_back({wd, m_stage});
        if (popo) m_seen = 0; else if (ordd) m_seen = 1;
        if (wr) case (a)
            A_CFG: m_cfg = wd; A_CFG2: m_cfg2 = wd; A_ILEN: m_stage = wd;
            A_ITHR: m_ithr = wd[3:0]; A_OTHR: m_othr = wd[3:0]; A_IEN: m_ien = wd[1];
            default: ;
        endcase
        @(posedge clk);
    endtask

    task automatic wr_reg(input logic [6:0] a, input logic [31:0] d);
        step(1, 0, a, d, 0, "");
    endtask
    task automatic rd_reg(input logic [6:0] a, input string tag);
        step(0, 1, a, 0, 0, tag);
    endtask
    task automatic submit(input logic [31:0] ad, input logic [31:0] ln);
        wr_reg(A_ILEN, ln); wr_reg(A_IADDR, ad);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin : main
        void'($urandom(32'h5EED_0A11));
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        // R1: reset state
        rd_reg(A_STAT, "R1 status");
        // R11: storage and zero-reading offsets
        wr_reg(A_ITHR, 32'hFFFF_FFF5); rd_reg(A_ITHR, "R11 ithr");
        wr_reg(A_CFG2, 32'hA5A5_0F0F); rd_reg(A_CFG2, "R11 cfg2");
        rd_reg(A_IADDR, "R11 iaddr"); rd_reg(7'h26, "R11 misaligned"); rd_reg(7'h3C, "R11 unmapped");
        // R7: empty completion reads
        rd_reg(A_OADDR, "R7 addr"); rd_reg(A_OLEN, "R7 len"); rd_reg(A_STAT, "R7 level");
        // R2/R3/R5: fill while stopped, then overflow
        for (int i = 0; i < D; i++) submit(32'h1000_0000 + 32'(i) * 32'h100, 32'h40 + 32'(i));
        rd_reg(A_STAT, "R2 full level");
        submit(32'hDEAD_0000, 32'h99);
        rd_reg(A_STAT, "R3 overflow");
        step(0, 0, A_CFG, 0, 1, "");          // R5: done while stopped ignored
        rd_reg(A_STAT, "R5 no consume");
        wr_reg(A_STAT, 32'h0000_0000); rd_reg(A_STAT, "R8 clear");
        // R4/R9: run, threshold 2
        wr_reg(A_IEN, 32'h2); wr_reg(A_OTHR, 32'h2); wr_reg(A_CFG, 32'h8000_0000);
        step(0, 0, A_CFG, 0, 1, ""); step(0, 0, A_CFG, 0, 0, "");
        step(0, 0, A_CFG, 0, 1, ""); step(0, 0, A_CFG, 0, 1, "");
        rd_reg(A_STAT, "R6 levels");
        // R6: length read without address read keeps the entry
        rd_reg(A_OLEN, "R6 len only"); rd_reg(A_STAT, "R6 no pop");
        rd_reg(A_OADDR, "R6 addr"); rd_reg(A_OLEN, "R6 len pop"); rd_reg(A_STAT, "R6 popped");
        // R10: completion and pop in the same cycle
        rd_reg(A_OADDR, "R10 addr");
        step(0, 1, A_OLEN, 0, 1, "R10 len");
        rd_reg(A_STAT, "R10 level");
        // R8: clearing write coinciding with a completion keeps the bit
        step(1, 0, A_STAT, 32'h0, 1, "");
        rd_reg(A_STAT, "R8 set wins");
        // Random traffic
        for (int c = 0; c < 4000; c++) begin
            int op = int'($urandom_range(0, 99));
            logic dn = ($urandom_range(0, 2) == 0);
            if (op < 20)       wr_reg(A_ILEN, $urandom());
            else if (op < 40)  step(1, 0, A_IADDR, $urandom(), dn, "");
            else if (op < 55)  step(0, 1, A_OADDR, 0, dn, "R6 rand addr");
            else if (op < 70)  step(0, 1, A_OLEN, 0, dn, "R6 rand len");
            else if (op < 78)  step(0, 1, A_STAT, 0, dn, "R2 rand status");
            else if (op < 82)  step(1, 0, A_STAT, 32'(($urandom_range(0, 1)) << 1) | 32'h4, dn, "");
            else if (op < 84)  step(1, 0, A_CFG, ($urandom_range(0, 5) != 0) ? 32'h8000_0000 : 32'h0, dn, "");
            else if (op < 86)  step(1, 0, A_OTHR, 32'($urandom_range(0, 9)), dn, "");
            else if (op < 87)  step(1, 0, A_IEN, 32'($urandom_range(0, 3)), dn, "");
            else if (op < 89)  step(1, 0, A_STAT, 32'h0, dn, "");
            else               step(0, 0, A_CFG, 0, dn, "");
        end
        @(negedge clk);
        bus_wr = 0; bus_rd = 0; eng_done = 0;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule